// File: doc/BRIEF.md
# Register Readiness Scoreboard

This block keeps, for every architectural register tag of an in-order multi-issue pipeline, a count of the cycles left before the most recent producer's result can be consumed. When a producer issues, it presents its operation class and destination tag. The matching entry loads a countdown from a latency table that depends on the class, and the countdown then drops by one each cycle until it reaches zero. Condition-code flags are tracked by giving them a tag of their own, like any other entry.

A consumer asks whether a source is usable by presenting its own class, the role of the operand (general/address, store data or condition code) and the source tag. Some producer/consumer pairs get a result earlier than the full latency. Examples are a chained floating-point add, a graphics add, a store's data operand and a branch that tests a compare's flags. The scoreboard grants these pairs a discount against the countdown, and it answers ready or stall in the same cycle, without a register. A producer issuing in the current cycle is already visible to the query, which is what allows zero-cycle pairs to go out together. The issue port is valid-only and has no ready: the scoreboard never back-pressures, and every producer presented with `iss_valid` high is taken unless flush is high.

Top module: `reg_ready_sb`

## Requirements
- R1: A synchronous reset clears every countdown, so all tags report ready in the first cycle after reset.
- R2: Tag 0 is hard-wired: queries on it always report ready, and issues to it are discarded.
- R3: Integer classes have these full latencies (class code in brackets): ALU [0], shift [1] and compare [2] take 1 cycle, conditional move [3] takes 2, load [4] takes 2 and signed load [5] takes 3. A consumer of such a result is ready when at least that many cycles have passed since the producer issued.
- R4: Other full latencies are: FP add/sub [6] and FP multiply [7] take 4, FP move [8] takes 1, FP conditional move [9] takes 2, single divide/sqrt [10] takes 13, double divide/sqrt [11] takes 23, graphics add [12] takes 2 and graphics multiply [13] takes 4. Store [14] and branch [15] produce nothing usable and count 0.
- R5: The data operand (role 1) of a store consumer [14] is ready in the producer's issue cycle when that producer is an ALU, shift, compare, FP add, FP multiply, FP move or FP conditional move. Every other producer, divides and loads included, still needs its full latency.
- R6: Address operands (role 0) of a store wait for the full latency.
- R7: A branch consumer [15] reading a compare's flags as a condition-code operand (role 2) is ready in the compare's issue cycle. No other producer, and no other role, gets this bypass.
- R8: For an FP add [6] or FP multiply [7] consumer, the latency is 3 cycles from FP add/multiply, 12 from a single divide and 22 from a double divide.
- R9: For a graphics add [12] consumer, the latency is 1 cycle from a graphics add and 3 from a graphics multiply.
- R10: A new issue to a tag replaces any countdown still pending for it.
- R11: Flush clears every entry at the clock edge. A producer issued in the flush cycle is dropped, and the query in the flush cycle does not see it.
- R12: A query on the tag being issued in the same cycle sees the new producer at its full count. Role code 3 behaves as role 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Clear all entries; drops a same-cycle issue |
| iss_valid | input | 1 | A producer issues this cycle |
| iss_class | input | 4 | Producer class code |
| iss_tag | input | TAG_W | Producer destination tag |
| q_class | input | 4 | Consumer class code |
| q_role | input | 2 | Operand role: 0 general/address, 1 store data, 2 condition code, 3 as 0 |
| q_tag | input | TAG_W | Source tag being queried |
| q_ready | output | 1 | Source is usable this cycle |

## Verification
The bench builds the block with its default 32 tags. Queries can therefore reach the top tag, and the 5-bit countdown is driven right up to the 23-cycle double divide. Each table row isolates one producer/consumer/role pair. It queries that pair once on the last stalling cycle and once on the first ready cycle, so an off-by-one error in either the load value or the discount shows up. Directed cases cover overwriting a long divide with a short ALU result, flushing with an issue in the same cycle, and reset during a pending countdown.

// File: rtl/rrsb_pkg.sv
package rrsb_pkg;

  localparam int CLS_W   = 4;
  localparam int ROLE_W  = 2;
  localparam int MAX_LAT = 23;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  typedef enum logic [CLS_W-1:0] {
    CL_IALU   = 4'd0,
    CL_SHIFT  = 4'd1,
    CL_CMP    = 4'd2,
    CL_CMOV   = 4'd3,
    CL_LOAD   = 4'd4,
    CL_SLOAD  = 4'd5,
    CL_FPADD  = 4'd6,
    CL_FPMUL  = 4'd7,
    CL_FMOV   = 4'd8,
    CL_FCMOV  = 4'd9,
    CL_FDIVS  = 4'd10,
    CL_FDIVD  = 4'd11,
    CL_GADD   = 4'd12,
    CL_GMUL   = 4'd13,
    CL_STORE  = 4'd14,
    CL_BRANCH = 4'd15
  } op_class_e;

  typedef enum logic [ROLE_W-1:0] {
    RL_GEN   = 2'd0,
    RL_STDAT = 2'd1,
    RL_CC    = 2'd2,
    RL_RSVD  = 2'd3
  } opnd_role_e;

  // Latency seen by a consumer that gets no bypass.
  function automatic logic [CNT_W-1:0] full_latency(op_class_e c);
    case (c)
      CL_IALU, CL_SHIFT, CL_CMP, CL_FMOV: return CNT_W'(1);
      CL_CMOV, CL_LOAD, CL_FCMOV, CL_GADD: return CNT_W'(2);
      CL_SLOAD:                           return CNT_W'(3);
      CL_FPADD, CL_FPMUL, CL_GMUL:        return CNT_W'(4);
      CL_FDIVS:                           return CNT_W'(13);
      CL_FDIVD:                           return CNT_W'(23);
      default:                            return '0;
    endcase
  endfunction

  // Producers whose result may feed a store's data in the issue cycle.
  function automatic logic store_data_src(op_class_e c);
    case (c)
      CL_IALU, CL_SHIFT, CL_CMP, CL_FPADD, CL_FPMUL, CL_FMOV, CL_FCMOV: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rrsb_entry.sv
module rrsb_entry
  import rrsb_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic [CW-1:0]    load_cnt,
  input  logic [CLS_W-1:0] load_cls,
  output logic [CW-1:0]    rem,
  output logic [CLS_W-1:0] cls
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rem <= '0;
      cls <= '0;
    end else if (load) begin
      rem <= load_cnt;
      cls <= load_cls;
    end else if (rem != '0) begin
      rem <= rem - 1'b1;
    end
  end

endmodule

// File: rtl/rrsb_fwd_calc.sv
module rrsb_fwd_calc
  import rrsb_pkg::*;
(
  input  logic [CLS_W-1:0]  prod_cls,
  input  logic [CNT_W-1:0]  prod_rem,
  input  logic [CLS_W-1:0]  cons_cls,
  input  logic [ROLE_W-1:0] role,
  output logic              ready
);

  op_class_e        p, c;
  opnd_role_e       r;
  logic [CNT_W-1:0] full, eff, discount;

  always_comb begin
    p    = op_class_e'(prod_cls);
    c    = op_class_e'(cons_cls);
    r    = opnd_role_e'(role);
    full = full_latency(p);
    eff  = full;
    if (c == CL_STORE && r == RL_STDAT) begin
      if (store_data_src(p)) eff = '0;
    end else if (c == CL_BRANCH && r == RL_CC) begin
      if (p == CL_CMP) eff = '0;
    end else if (c == CL_FPADD || c == CL_FPMUL) begin
      case (p)
        CL_FPADD, CL_FPMUL: eff = CNT_W'(3);
        CL_FDIVS:           eff = CNT_W'(12);
        CL_FDIVD:           eff = CNT_W'(22);
        default:            eff = full;
      endcase
    end else if (c == CL_GADD) begin
      case (p)
        CL_GADD: eff = CNT_W'(1);
        CL_GMUL: eff = CNT_W'(3);
        default: eff = full;
      endcase
    end
    discount = full - eff;
    ready    = (prod_rem <= discount);
  end

endmodule

// File: rtl/reg_ready_sb.sv
module reg_ready_sb
  import rrsb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int TAG_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             iss_valid,
  input  logic [3:0]       iss_class,
  input  logic [TAG_W-1:0] iss_tag,
  input  logic [3:0]       q_class,
  input  logic [1:0]       q_role,
  input  logic [TAG_W-1:0] q_tag,
  output logic             q_ready
);

  logic [CNT_W-1:0] rem_q [NUM_REGS];
  logic [CLS_W-1:0] cls_q [NUM_REGS];
  logic [CNT_W-1:0] iss_full, iss_load;
  logic             take, fwd, calc_ready;
  logic [CNT_W-1:0] sel_rem;
  logic [CLS_W-1:0] sel_cls;

  always_comb begin
    iss_full = full_latency(op_class_e'(iss_class));
    iss_load = (iss_full == '0) ? '0 : iss_full - 1'b1;
    take     = iss_valid && !flush;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_ent
    if (g == 0) begin : g_zero
      assign rem_q[g] = '0;
      assign cls_q[g] = '0;
    end else begin : g_live
      rrsb_entry #(.CW(CNT_W)) u_ent (
        .clk      (clk),
        .rst      (rst),
        .clr      (flush),
        .load     (take && (iss_tag == TAG_W'(g))),
        .load_cnt (iss_load),
        .load_cls (iss_class),
        .rem      (rem_q[g]),
        .cls      (cls_q[g])
      );
    end
  end

  always_comb begin
    fwd     = take && !rst && (iss_tag == q_tag);
    sel_rem = fwd ? iss_full  : rem_q[q_tag];
    sel_cls = fwd ? iss_class : cls_q[q_tag];
  end

  rrsb_fwd_calc u_calc (
    .prod_cls (sel_cls),
    .prod_rem (sel_rem),
    .cons_cls (q_class),
    .role     (q_role),
    .ready    (calc_ready)
  );

  assign q_ready = (q_tag == '0) || calc_ready;

endmodule

// File: rtl/reg_ready_sb_chk.sv
module reg_ready_sb_chk #(
  parameter int TAG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             iss_valid,
  input logic [3:0]       iss_class,
  input logic [TAG_W-1:0] iss_tag,
  input logic [3:0]       q_class,
  input logic [1:0]       q_role,
  input logic [TAG_W-1:0] q_tag,
  input logic             q_ready
);

  logic same_tag;
  assign same_tag = iss_valid && (iss_tag == q_tag);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !same_tag) |-> q_ready);

  assert_flush_clear_R11: assert property (@(posedge clk) disable iff (rst)
    ($past(flush) && !same_tag) |-> q_ready);

  // class 0 ALU -> class 14 store, role 1 data
  assert_store_data_bypass_R5: assert property (@(posedge clk) disable iff (rst)
    (same_tag && !flush && iss_class == 4'd0 && q_class == 4'd14 && q_role == 2'd1) |-> q_ready);

  // class 11 double divide, role 0, nonzero tag
  assert_divide_stalls_R6: assert property (@(posedge clk) disable iff (rst)
    (same_tag && !flush && iss_class == 4'd11 && q_tag != '0 && q_role == 2'd0) |-> !q_ready);

  // class 2 compare -> class 15 branch, role 2 flags
  assert_cc_bypass_R7: assert property (@(posedge clk) disable iff (rst)
    (same_tag && !flush && iss_class == 4'd2 && q_class == 4'd15 && q_role == 2'd2) |-> q_ready);

  assert_alu_next_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !flush && iss_class == 4'd0) |=>
      ((q_tag == $past(iss_tag) && !same_tag && !flush) -> q_ready));

endmodule

bind reg_ready_sb reg_ready_sb_chk #(.TAG_W(TAG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .flush     (flush),
  .iss_valid (iss_valid),
  .iss_class (iss_class),
  .iss_tag   (iss_tag),
  .q_class   (q_class),
  .q_role    (q_role),
  .q_tag     (q_tag),
  .q_ready   (q_ready)
);

// File: tb/reg_ready_sb_bench.sv
module reg_ready_sb_bench;

  localparam int TW = 5;
  // class codes
  localparam logic [3:0] IALU = 0, SHFT = 1, CMP = 2, CMOV = 3, LD = 4, SLD = 5,
                         FADD = 6, FMUL = 7, FMOV = 8, FCMV = 9, DIVS = 10,
                         DIVD = 11, GADD = 12, GMUL = 13, ST = 14, BR = 15;

  logic          clk = 0, rst = 1, flush = 0, iss_valid = 0;
  logic [3:0]    iss_class = 0, q_class = 0;
  logic [TW-1:0] iss_tag = 0, q_tag = 0;
  logic [1:0]    q_role = 0;
  logic          q_ready;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  reg_ready_sb u_reg_ready_sb (
    .clk(clk), .rst(rst), .flush(flush), .iss_valid(iss_valid),
    .iss_class(iss_class), .iss_tag(iss_tag), .q_class(q_class),
    .q_role(q_role), .q_tag(q_tag), .q_ready(q_ready)
  );

  // {req, producer, consumer, role, cycles after issue, expected ready}
  localparam int NV = 40;
  localparam logic [19:0] VEC [NV] = '{
    {4'd3,  IALU, IALU, 2'd0, 5'd0,  1'b0}, {4'd3,  IALU, IALU, 2'd0, 5'd1,  1'b1},
    {4'd3,  LD,   IALU, 2'd0, 5'd1,  1'b0}, {4'd3,  LD,   IALU, 2'd0, 5'd2,  1'b1},
    {4'd3,  SLD,  IALU, 2'd0, 5'd2,  1'b0}, {4'd3,  SLD,  IALU, 2'd0, 5'd3,  1'b1},
    {4'd3,  CMOV, IALU, 2'd0, 5'd1,  1'b0}, {4'd3,  CMOV, IALU, 2'd0, 5'd2,  1'b1},
    {4'd4,  FADD, IALU, 2'd0, 5'd3,  1'b0}, {4'd4,  FADD, IALU, 2'd0, 5'd4,  1'b1},
    {4'd4,  DIVS, IALU, 2'd0, 5'd12, 1'b0}, {4'd4,  DIVS, IALU, 2'd0, 5'd13, 1'b1},
    {4'd4,  GMUL, IALU, 2'd0, 5'd3,  1'b0}, {4'd4,  GADD, IALU, 2'd0, 5'd1,  1'b0},
    {4'd4,  GADD, IALU, 2'd0, 5'd2,  1'b1}, {4'd4,  ST,   IALU, 2'd0, 5'd0,  1'b1},
    {4'd8,  FADD, FMUL, 2'd0, 5'd2,  1'b0}, {4'd8,  FADD, FMUL, 2'd0, 5'd3,  1'b1},
    {4'd8,  DIVS, FADD, 2'd0, 5'd11, 1'b0}, {4'd8,  DIVS, FADD, 2'd0, 5'd12, 1'b1},
    {4'd8,  DIVD, FMUL, 2'd0, 5'd21, 1'b0}, {4'd8,  DIVD, FMUL, 2'd0, 5'd22, 1'b1},
    {4'd5,  DIVD, ST,   2'd1, 5'd22, 1'b0}, {4'd5,  DIVD, ST,   2'd1, 5'd23, 1'b1},
    {4'd5,  IALU, ST,   2'd1, 5'd0,  1'b1}, {4'd5,  FMOV, ST,   2'd1, 5'd0,  1'b1},
    {4'd5,  FMUL, ST,   2'd1, 5'd0,  1'b1}, {4'd5,  FCMV, ST,   2'd1, 5'd0,  1'b1},
    {4'd5,  DIVS, ST,   2'd1, 5'd0,  1'b0}, {4'd5,  LD,   ST,   2'd1, 5'd0,  1'b0},
    {4'd6,  SHFT, ST,   2'd0, 5'd0,  1'b0}, {4'd6,  SHFT, ST,   2'd0, 5'd1,  1'b1},
    {4'd7,  CMP,  BR,   2'd2, 5'd0,  1'b1}, {4'd7,  CMP,  BR,   2'd0, 5'd0,  1'b0},
    {4'd7,  FADD, BR,   2'd2, 5'd0,  1'b0}, {4'd9,  GADD, GADD, 2'd0, 5'd0,  1'b0},
    {4'd9,  GADD, GADD, 2'd0, 5'd1,  1'b1}, {4'd9,  GMUL, GADD, 2'd0, 5'd2,  1'b0},
    {4'd9,  GMUL, GADD, 2'd0, 5'd3,  1'b1}, {4'd12, CMP,  ST,   2'd3, 5'd0,  1'b0}
  };

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd3: return "R3";   4'd4: return "R4";   4'd5: return "R5";
      4'd6: return "R6";   4'd7: return "R7";   4'd8: return "R8";
      4'd9: return "R9";   default: return "R12";
    endcase
  endfunction

  task automatic check(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: q_ready=%0b expected %0b (t=%0t)", req, got, exp, $time);
    end
  endtask

  task automatic query(input logic [TW-1:0] t, input logic [3:0] c, input logic [1:0] r);
    q_tag = t; q_class = c; q_role = r;
  endtask

  task automatic issue(input logic [TW-1:0] t, input logic [3:0] c);
    iss_valid = 1; iss_tag = t; iss_class = c;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 0;
    // R1: reset state, all tags ready
    query(5'd1, IALU, 2'd0);  #1 check("R1", q_ready, 1'b1);
    query(5'd31, FADD, 2'd0); #1 check("R1", q_ready, 1'b1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk); flush = 1; iss_valid = 0;
      @(negedge clk); flush = 0;
      issue(5'd5, VEC[i][15:12]);
      query(5'd5, VEC[i][11:8], VEC[i][7:6]);
      if (VEC[i][5:1] != 0) begin
        @(negedge clk); iss_valid = 0;
        repeat (int'(VEC[i][5:1]) - 1) @(negedge clk);
      end
      #1 check(req_name(VEC[i][19:16]), q_ready, VEC[i][0]);
      iss_valid = 0;
    end

    // R2: tag 0 ignores a long producer
    @(negedge clk); issue(5'd0, DIVD); query(5'd0, IALU, 2'd0);
    #1 check("R2", q_ready, 1'b1);
    @(negedge clk); iss_valid = 0; #1 check("R2", q_ready, 1'b1);

    // R10: ALU overwrites pending double divide
    @(negedge clk); issue(5'd7, DIVD); query(5'd7, IALU, 2'd0);
    @(negedge clk); iss_valid = 0;
    @(negedge clk); issue(5'd7, IALU); #1 check("R10", q_ready, 1'b0);
    @(negedge clk); iss_valid = 0; #1 check("R10", q_ready, 1'b1);

    // R11: flush clears a pending entry
    @(negedge clk); issue(5'd9, DIVD); query(5'd9, IALU, 2'd0);
    @(negedge clk); iss_valid = 0; #1 check("R11", q_ready, 1'b0);
    flush = 1;
    @(negedge clk); flush = 0; #1 check("R11", q_ready, 1'b1);
    // R11: issue in flush cycle is dropped and invisible
    @(negedge clk); flush = 1; issue(5'd9, DIVD); #1 check("R11", q_ready, 1'b1);
    @(negedge clk); flush = 0; iss_valid = 0; #1 check("R11", q_ready, 1'b1);

    // R1: reset during a pending countdown
    @(negedge clk); issue(5'd3, DIVD); query(5'd3, IALU, 2'd0);
    @(negedge clk); iss_valid = 0; #1 check("R1", q_ready, 1'b0);
    rst = 1;
    @(negedge clk); rst = 0; #1 check("R1", q_ready, 1'b1);

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule